// File: doc/BRIEF.md
# Mixed-Signedness Integer Multiply Unit

This block is the multiply engine of a 64-bit integer core. The core issues one operation per cycle: two XLEN-bit operands, an operation code, a valid strobe and a destination tag. After a fixed number of clock edges the unit returns one XLEN-bit result, together with the same tag and a result-valid pulse. No operand pair raises a fault. Every combination of operands yields a defined result, and the unit has no exception outputs.

There is a single multiplier. Before the multiply, each operand is widened by one bit, with sign extension or zero extension chosen by the operation. One signed product of the two widened operands then serves every operation. From that product the unit takes the low half, the high half for any of three signedness pairings, or a 32-bit word product sign-extended to full width.

A `stall` input freezes every stage of the pipeline. Nothing in flight is lost or duplicated, and no new operation is taken while `stall` is high.

Top module: `imul_unit`

## Requirements
- R1: Operation code 0 returns bits [XLEN-1:0] of the operand product. This value does not depend on whether the operands are read as signed or unsigned.
- R2: Operation code 1 returns bits [2*XLEN-1:XLEN] of the product with both operands read as signed two's-complement values.
- R3: Operation code 2 returns bits [2*XLEN-1:XLEN] of the product with both operands read as unsigned values.
- R4: Operation code 3 returns bits [2*XLEN-1:XLEN] of the product of `in_a` read as signed and `in_b` read as unsigned.
- R5: Operation code 4 multiplies bits [31:0] of each operand and returns bits [31:0] of that product, with bit 31 copied into every higher bit. Operand bits above bit 31 have no effect on the result.
- R6: Suppose an operation is presented with `in_valid` high and `stall` low at rising edge E. Its result and tag appear with `out_valid` high just after edge E+LAT-1 (LAT defaults to 3). If `stall` stays low, `out_valid` is high for exactly one cycle.
- R7: Operations presented on consecutive cycles leave the unit one per cycle, in issue order, each with its own tag.
- R8: While `stall` is high, `out_valid`, `out_result` and `out_tag` hold their values, and an operation presented during that time is discarded. When `stall` is released, the operations already in flight complete in order.
- R9: While `rst` is high, and in the first cycle after it is released, `out_valid` is low and `out_tag` is zero. During reset `out_result` is also zero.
- R10: Operation codes 5, 6 and 7 behave like code 0 and return the low half of the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freeze every pipeline stage |
| in_valid | input | 1 | Operation present on the inputs |
| in_op | input | 3 | Operation code (0 low, 1 high s×s, 2 high u×u, 3 high s×u, 4 word) |
| in_a | input | XLEN | First operand |
| in_b | input | XLEN | Second operand |
| in_tag | input | TAGW | Destination tag carried with the operation |
| out_valid | output | 1 | Result present on the outputs |
| out_result | output | XLEN | Selected product bits |
| out_tag | output | TAGW | Tag of the operation that produced the result |

## Verification
An operation accepted at edge E has its result due just after edge E+LAT-1. With the default latency that is two edges after acceptance. A monitor compares results against an in-order queue of expected values. It samples one time unit before each rising edge, and it counts an output as taken only when `stall` is low at that point, so a stalled result is neither skipped nor counted twice. The latency scenario checks `out_valid` at every falling edge from acceptance through LAT+1 cycles, so an early, late or stretched result is caught. The stall scenario compares the outputs at each falling edge of the freeze, and it feeds operations during the freeze that must never come out.

// File: rtl/mul_pkg.sv
package mul_pkg;

    // Operation codes presented on in_op
    typedef enum logic [2:0] {
        MUL_LO   = 3'd0,
        MUL_HSS  = 3'd1,
        MUL_HUU  = 3'd2,
        MUL_HSU  = 3'd3,
        MUL_WORD = 3'd4
    } mul_op_e;

    // Width of the word-sized multiply
    localparam int WORD_BITS = 32;

endpackage

// File: rtl/mul_opnd_ext.sv
module mul_opnd_ext
    import mul_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  mul_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN:0]   ax,
    output logic [XLEN:0]   bx
);
    localparam int WPAD = XLEN + 1 - WORD_BITS;

    logic [XLEN:0] a_sx, a_zx, a_wx;
    logic [XLEN:0] b_sx, b_zx, b_wx;

    assign a_sx = {a[XLEN-1], a};
    assign a_zx = {1'b0, a};
    assign a_wx = {{WPAD{a[WORD_BITS-1]}}, a[WORD_BITS-1:0]};
    assign b_sx = {b[XLEN-1], b};
    assign b_zx = {1'b0, b};
    assign b_wx = {{WPAD{b[WORD_BITS-1]}}, b[WORD_BITS-1:0]};

    // Widening choice per operation; the low product is sign-agnostic
    always_comb begin
        case (op)
            MUL_HSS: begin
                ax = a_sx;
                bx = b_sx;
            end
            MUL_HUU: begin
                ax = a_zx;
                bx = b_zx;
            end
            MUL_HSU: begin
                ax = a_sx;
                bx = b_zx;
            end
            MUL_WORD: begin
                ax = a_wx;
                bx = b_wx;
            end
            default: begin
                ax = a_zx;
                bx = b_zx;
            end
        endcase
    end

endmodule

// File: rtl/mul_pipe_reg.sv
module mul_pipe_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stall,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] r_d, r_q;

    always_comb begin
        r_d = stall ? r_q : d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign q = r_q;

endmodule

// File: rtl/mul_res_sel.sv
module mul_res_sel
    import mul_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  mul_op_e           op,
    input  logic [2*XLEN-1:0] prod,
    output logic [XLEN-1:0]   res
);
    logic [XLEN-1:0] lo_half, hi_half, word_res;

    assign lo_half = prod[XLEN-1:0];
    assign hi_half = prod[2*XLEN-1:XLEN];

    generate
        if (XLEN > WORD_BITS) begin : g_word_ext
            assign word_res = {{(XLEN-WORD_BITS){prod[WORD_BITS-1]}}, prod[WORD_BITS-1:0]};
        end else begin : g_word_flat
            assign word_res = lo_half;
        end
    endgenerate

    always_comb begin
        case (op)
            MUL_HSS, MUL_HUU, MUL_HSU: res = hi_half;
            MUL_WORD:                  res = word_res;
            default:                   res = lo_half;
        endcase
    end

endmodule

// File: rtl/imul_unit.sv
module imul_unit
    import mul_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int TAGW = 5,
    parameter int LAT  = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall,
    input  logic            in_valid,
    input  logic [2:0]      in_op,
    input  logic [XLEN-1:0] in_a,
    input  logic [XLEN-1:0] in_b,
    input  logic [TAGW-1:0] in_tag,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result,
    output logic [TAGW-1:0] out_tag
);
    // LAT counts operand stage + product stage + delay stages (LAT >= 2)
    localparam int NDLY = LAT - 2;

    typedef struct packed {
        logic            vld;
        logic [TAGW-1:0] tag;
        mul_op_e         op;
        logic [XLEN:0]   ax;
        logic [XLEN:0]   bx;
    } opnd_stage_t;

    typedef struct packed {
        logic              vld;
        logic [TAGW-1:0]   tag;
        mul_op_e           op;
        logic [2*XLEN-1:0] prod;
    } prod_stage_t;

    localparam int PW = $bits(prod_stage_t);

    opnd_stage_t       sa_d, sa_q;
    prod_stage_t       sp_d, sp_q;
    logic [XLEN:0]     ext_a, ext_b;
    logic [2*XLEN-1:0] prod_w;
    mul_op_e           op_in;

    assign op_in = mul_op_e'(in_op);

    mul_opnd_ext #(.XLEN(XLEN)) u_ext (
        .op (op_in),
        .a  (in_a),
        .b  (in_b),
        .ax (ext_a),
        .bx (ext_b)
    );

    // One signed (XLEN+1)x(XLEN+1) multiply, kept to 2*XLEN bits
    assign prod_w = $signed(sa_q.ax) * $signed(sa_q.bx);

    always_comb begin
        sa_d = sa_q;
        sp_d = sp_q;
        if (!stall) begin
            sa_d.vld  = in_valid;
            sa_d.tag  = in_tag;
            sa_d.op   = op_in;
            sa_d.ax   = ext_a;
            sa_d.bx   = ext_b;
            sp_d.vld  = sa_q.vld;
            sp_d.tag  = sa_q.tag;
            sp_d.op   = sa_q.op;
            sp_d.prod = prod_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sa_q <= '0;
            sp_q <= '0;
        end else begin
            sa_q <= sa_d;
            sp_q <= sp_d;
        end
    end

    // Delay stages that pad the product to the requested latency
    logic [PW-1:0] chain [0:NDLY];
    assign chain[0] = sp_q;

    generate
        for (genvar i = 0; i < NDLY; i++) begin : g_dly
            mul_pipe_reg #(.W(PW)) u_dly (
                .clk   (clk),
                .rst   (rst),
                .stall (stall),
                .d     (chain[i]),
                .q     (chain[i+1])
            );
        end
    endgenerate

    prod_stage_t fin;
    logic [2:0]  fin_op_w;
    assign fin      = chain[NDLY];
    assign fin_op_w = fin.op;

    mul_res_sel #(.XLEN(XLEN)) u_sel (
        .op   (fin.op),
        .prod (fin.prod),
        .res  (out_result)
    );

    assign out_valid = fin.vld;
    assign out_tag   = fin.tag;

endmodule

// File: rtl/imul_unit_chk.sv
module imul_unit_chk #(
    parameter int XLEN = 64,
    parameter int TAGW = 5,
    parameter int LAT  = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            stall,
    input logic            in_valid,
    input logic            out_valid,
    input logic [XLEN-1:0] out_result,
    input logic [TAGW-1:0] out_tag,
    input logic [2:0]      fin_op
);
    localparam int CW = $clog2(LAT + 2) + 1;

    // Occupancy: entries taken in minus results handed out
    logic [CW-1:0] occ_q;
    logic          take, give;
    assign take = in_valid && !stall;
    assign give = out_valid && !stall;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + CW'(take) - CW'(give);
        end
    end

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(out_valid) && $stable(out_result) && $stable(out_tag)));

    assert_idle_after_reset_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && out_tag == '0));

    assert_inflight_bound_R6: assert property (@(posedge clk) disable iff (rst)
        occ_q <= CW'(LAT));

    assert_valid_has_entry_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (occ_q != '0));

    generate
        if (XLEN > 32) begin : g_word_chk
            assert_word_sext_R5: assert property (@(posedge clk) disable iff (rst)
                (out_valid && fin_op == 3'd4) |->
                    (out_result[XLEN-1:32] == {(XLEN-32){out_result[31]}}));
        end
    endgenerate

endmodule

bind imul_unit imul_unit_chk #(.XLEN(XLEN), .TAGW(TAGW), .LAT(LAT)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .stall      (stall),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_tag    (out_tag),
    .fin_op     (fin_op_w)
);

// File: tb/imul_unit_tb_top.sv
module imul_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 64;
    localparam int TAGW = 5;
    localparam int LAT  = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            stall = 1'b0;
    logic            in_valid = 1'b0;
    logic [2:0]      in_op = '0;
    logic [XLEN-1:0] in_a = '0;
    logic [XLEN-1:0] in_b = '0;
    logic [TAGW-1:0] in_tag = '0;
    logic            out_valid;
    logic [XLEN-1:0] out_result;
    logic [TAGW-1:0] out_tag;

    int n_checks = 0;
    int n_fail   = 0;

    logic [XLEN-1:0] exp_q[$];
    logic [TAGW-1:0] tag_q[$];
    string           req_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    imul_unit #(.XLEN(XLEN), .TAGW(TAGW), .LAT(LAT)) dut_i (
        .clk(clk), .rst(rst), .stall(stall), .in_valid(in_valid),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_tag(in_tag),
        .out_valid(out_valid), .out_result(out_result), .out_tag(out_tag)
    );

    // Reference from the requirements: 128-bit arithmetic on widened operands
    function automatic logic [63:0] model(logic [2:0] op, logic [63:0] a, logic [63:0] b);
        logic [127:0] ea, eb, p;
        case (op)
            3'd1: begin ea = {{64{a[63]}}, a}; eb = {{64{b[63]}}, b}; p = ea * eb; return p[127:64]; end
            3'd2: begin ea = {64'd0, a}; eb = {64'd0, b}; p = ea * eb; return p[127:64]; end
            3'd3: begin ea = {{64{a[63]}}, a}; eb = {64'd0, b}; p = ea * eb; return p[127:64]; end
            3'd4: begin ea = {96'd0, a[31:0]}; eb = {96'd0, b[31:0]}; p = ea * eb;
                        return {{32{p[31]}}, p[31:0]}; end
            default: begin ea = {64'd0, a}; eb = {64'd0, b}; p = ea * eb; return p[63:0]; end
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // Present one operation for one cycle; queue its expected result if taken
    task automatic put(logic [2:0] op, logic [63:0] a, logic [63:0] b, logic [TAGW-1:0] tag, string req);
        in_op = op; in_a = a; in_b = b; in_tag = tag; in_valid = 1'b1;
        if (!stall) begin
            exp_q.push_back(model(op, a, b));
            tag_q.push_back(tag);
            req_q.push_back(req);
        end
        tick();
        in_valid = 1'b0;
    endtask

    task automatic drain(string req);
        repeat (LAT + 3) tick();
        check(exp_q.size() == 0, req, "results outstanding after drain", 64'(exp_q.size()), 64'd0);
    endtask

    // Monitor: one time unit before each rising edge, an unstalled result is taken
    always @(negedge clk) begin
        #(CLK_PERIOD/2 - 1);
        if (!rst && out_valid && !stall) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected result", out_result, 64'd0);
            end else begin
                logic [63:0]     e;
                logic [TAGW-1:0] t;
                string           r;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                r = req_q.pop_front();
                check(out_result == e, r, "result", out_result, e);
                check(out_tag == t, r, "tag", 64'(out_tag), 64'(t));
            end
        end
    end

    task automatic t_reset();
        repeat (3) tick();
        check(out_valid == 1'b0, "R9", "out_valid in reset", 64'(out_valid), 64'd0);
        check(out_result == '0, "R9", "out_result in reset", out_result, 64'd0);
        check(out_tag == '0, "R9", "out_tag in reset", 64'(out_tag), 64'd0);
        rst = 1'b0;
        tick();
        check(out_valid == 1'b0, "R9", "out_valid after release", 64'(out_valid), 64'd0);
    endtask

    task automatic t_low();
        put(3'd0, 64'd6, 64'd7, 5'd1, "R1");
        put(3'd0, 64'hFFFF_FFFF_FFFF_FFFD, 64'd5, 5'd2, "R1");
        put(3'd0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 5'd3, "R1");
        put(3'd0, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 5'd4, "R1");
        put(3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 5'd5, "R10");
        put(3'd6, 64'd123456789, 64'hFFFF_FFFF_0000_0001, 5'd6, "R10");
        put(3'd7, 64'h8000_0000_0000_0001, 64'd3, 5'd7, "R10");
        drain("R1");
    endtask

    task automatic t_high_ss();
        put(3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 5'd8, "R2");
        put(3'd1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 5'd9, "R2");
        put(3'd1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 5'd10, "R2");
        put(3'd1, 64'hFFFF_FFFF_FFFF_FFFD, 64'd5, 5'd11, "R2");
        put(3'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 5'd12, "R2");
        drain("R2");
    endtask

    task automatic t_high_uu();
        put(3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 5'd13, "R3");
        put(3'd2, 64'h8000_0000_0000_0000, 64'd2, 5'd14, "R3");
        put(3'd2, 64'hFFFF_FFFF_FFFF_FFFD, 64'd5, 5'd15, "R3");
        drain("R3");
    endtask

    task automatic t_high_su();
        put(3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 5'd16, "R4");
        put(3'd3, 64'd2, 64'hFFFF_FFFF_FFFF_FFFF, 5'd17, "R4");
        put(3'd3, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 5'd18, "R4");
        drain("R4");
    endtask

    task automatic t_word();
        put(3'd4, 64'hDEAD_BEEF_7FFF_FFFF, 64'hCAFE_0000_0000_0002, 5'd19, "R5");
        put(3'd4, 64'h0000_0001_0001_0000, 64'hFFFF_FFFF_0001_0000, 5'd20, "R5");
        put(3'd4, 64'h0000_0000_FFFF_FFFF, 64'h1234_5678_FFFF_FFFF, 5'd21, "R5");
        put(3'd4, 64'hFFFF_FFFF_0000_4000, 64'h0000_0000_0000_4000, 5'd22, "R5");
        drain("R5");
    endtask

    task automatic t_latency();
        put(3'd1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 5'd23, "R6");
        for (int k = 1; k <= LAT + 1; k++) begin
            check(out_valid == (k == LAT), "R6", $sformatf("out_valid %0d cycles on", k),
                  64'(out_valid), 64'(k == LAT));
            tick();
        end
        drain("R6");
    endtask

    task automatic t_stream();
        logic [63:0] x = 64'h9E37_79B9_7F4A_7C15;
        logic [63:0] a, b;
        for (int i = 0; i < 12; i++) begin
            x = x * 64'd6364136223846793005 + 64'd1442695040888963407;
            a = x;
            x = x * 64'd6364136223846793005 + 64'd1442695040888963407;
            b = x;
            put(3'(i % 5), a, b, 5'(i + 1), "R7");
        end
        drain("R7");
    endtask

    task automatic t_stall();
        logic            sv;
        logic [63:0]     sr;
        logic [TAGW-1:0] st;
        put(3'd2, 64'hFFFF_0000_FFFF_0000, 64'h0000_FFFF_0000_FFFF, 5'd24, "R8");
        put(3'd1, 64'hFFFF_FFFF_FFFF_FF00, 64'd300, 5'd25, "R8");
        put(3'd4, 64'hAAAA_AAAA_8000_0000, 64'd1, 5'd26, "R8");
        stall = 1'b1;
        in_valid = 1'b1; in_op = 3'd0; in_a = 64'hBAD; in_b = 64'h5; in_tag = 5'd31;
        tick();
        sv = out_valid; sr = out_result; st = out_tag;
        check(sv == 1'b1, "R8", "result present at freeze", 64'(sv), 64'd1);
        for (int k = 0; k < 4; k++) begin
            in_a = in_a + 64'd1;
            tick();
            check(out_valid == sv, "R8", "out_valid held", 64'(out_valid), 64'(sv));
            check(out_result == sr, "R8", "out_result held", out_result, sr);
            check(out_tag == st, "R8", "out_tag held", 64'(out_tag), 64'(st));
        end
        stall = 1'b0;
        in_valid = 1'b0;
        drain("R8");
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_up();
    end

    initial begin
        t_reset();
        t_low();
        t_high_ss();
        t_high_uu();
        t_high_su();
        t_word();
        t_latency();
        t_stream();
        t_stall();
        finish_up();
    end

endmodule